// File: doc/BRIEF.md
# Scatter/Gather Descriptor Walker

This block follows a chain of 16-byte scatter/gather entries held in memory and turns them into a stream of transfer segments. Each segment is a 64-bit address and a byte count. A start pulse gives the address of the first entry. The walker then fetches each entry one 32-bit word at a time through a simple read port. A data entry becomes one or more segments, each no longer than a configurable limit. A link entry sends the walk to another table. The entry flagged as terminal ends the walk.

Tables are groups of four contiguous entries, so a walk normally runs through consecutive entries and jumps at a link. A downstream data mover takes the segments through a valid/ready handshake. When the walk ends, the block raises done, or raises error if the chain is malformed. It also reports the total number of bytes it has handed out.

Top module: `sg_walker`

## Requirements
- R1: An entry is read as four 32-bit words at byte offsets +0 (address low), +4 (address high), +8 (byte count) and +12 (flags), in that order, at word-aligned addresses. The four low bits of `start_addr` are ignored, so the first entry is taken at `start_addr` with bits 3:0 cleared.
- R2: A data entry (flags bit 30 clear) with a nonzero byte count produces segments that cover the region from its 64-bit address onward, in ascending address order. Each segment carries MAX_SEG bytes except the last, which carries the remainder.
- R3: After a non-terminal data entry, the next entry is read at the current entry address plus 16.
- R4: A link entry (flags bit 30 set) continues the walk at the 64-bit address it holds. Its byte count and its flags bits 29:0 have no effect on the walk. Flags bits 29 and 28 do not change how a data entry is treated.
- R5: Flags bit 31 (terminal) ends the walk after the entry's segments have been handed out. On a link entry it ends the walk without following the link.
- R6: A data entry with a byte count of zero produces no segment, but its terminal flag is still honoured.
- R7: A link whose address has any of bits 3:0 set raises error and stops the walk. No further read is issued.
- R8: A walk that would need more than MAX_ENTRIES entries raises error once MAX_ENTRIES entries have been read. The next entry is never read. A walk of exactly MAX_ENTRIES entries completes normally.
- R9: When the walk ends with segments, done rises in the clock cycle after the last segment is accepted.
- R10: `total_bytes` equals the sum of the accepted segment lengths. done, error and `total_bytes` hold until the next accepted start, and a start is ignored while a walk is in progress.
- R11: While `seg_valid` is high and `seg_ready` is low, `seg_valid`, `seg_addr` and `seg_len` stay unchanged.
- R12: After reset the block is idle: no read request, no segment, done and error low, `total_bytes` zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a walk (taken only when idle) |
| start_addr | input | 64 | Address of the first entry |
| rd_req | output | 1 | One-cycle word read request |
| rd_addr | output | 64 | Byte address of the requested word |
| rd_valid | input | 1 | Read data returned this cycle |
| rd_data | input | 32 | Returned word |
| seg_valid | output | 1 | Segment offered |
| seg_ready | input | 1 | Segment accepted when high with seg_valid |
| seg_addr | output | 64 | Segment start address |
| seg_len | output | 32 | Segment length in bytes |
| done | output | 1 | Walk finished normally |
| error | output | 1 | Walk aborted (misaligned link or entry limit) |
| total_bytes | output | TOT_W | Bytes handed out in the current walk |

## Verification
The case that is hardest to reach from the ports is the entry limit. The walk must run through exactly MAX_ENTRIES entries, and the check must show that the entry one past the limit is never fetched. The bench reduces MAX_ENTRIES to four and builds a chain of five single-byte data entries. It then counts the read requests, which must be exactly sixteen, along with the segments. The same chain with the terminal flag moved onto the fourth entry must finish cleanly.

// File: rtl/sg_walker.sv
module sg_walker #(
  parameter int MAX_SEG     = 4096,
  parameter int MAX_ENTRIES = 16,
  parameter int TOT_W       = 40
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [63:0]      start_addr,
  output logic             rd_req,
  output logic [63:0]      rd_addr,
  input  logic             rd_valid,
  input  logic [31:0]      rd_data,
  output logic             seg_valid,
  output logic [63:0]      seg_addr,
  output logic [31:0]      seg_len,
  input  logic             seg_ready,
  output logic             done,
  output logic             error,
  output logic [TOT_W-1:0] total_bytes
);
  localparam int CNT_W = $clog2(MAX_ENTRIES + 1);
  localparam logic [31:0] SEG_MAX = 32'(MAX_SEG);
  localparam logic [CNT_W-1:0] ENT_LIMIT = CNT_W'(MAX_ENTRIES);

  typedef enum logic [2:0] {S_IDLE, S_REQ, S_WAIT, S_DEC, S_EMIT, S_NEXT} st_t;

  st_t              st;
  logic [63:0]      ent_addr, cur;
  logic [1:0]       widx;
  logic [31:0]      w_lo, w_hi, w_cnt, remain;
  logic             f_trm, f_lnk;
  logic [CNT_W-1:0] ent_cnt;
  logic             done_r, err_r;
  logic [TOT_W-1:0] total;
  logic             last_seg;

  assign rd_req      = (st == S_REQ);
  assign rd_addr     = {ent_addr[63:4], widx, 2'b00};
  assign seg_valid   = (st == S_EMIT);
  assign seg_addr    = cur;
  assign seg_len     = (remain > SEG_MAX) ? SEG_MAX : remain;
  assign last_seg    = (remain <= SEG_MAX);
  assign done        = done_r;
  assign error       = err_r;
  assign total_bytes = total;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;
      ent_addr <= '0;
      cur <= '0;
      widx <= '0;
      w_lo <= '0;
      w_hi <= '0;
      w_cnt <= '0;
      remain <= '0;
      f_trm <= 1'b0;
      f_lnk <= 1'b0;
      ent_cnt <= '0;
      done_r <= 1'b0;
      err_r <= 1'b0;
      total <= '0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          ent_addr <= start_addr & ~64'hF;
          widx <= '0;
          ent_cnt <= '0;
          total <= '0;
          done_r <= 1'b0;
          err_r <= 1'b0;
          st <= S_REQ;
        end
        S_REQ: st <= S_WAIT;
        S_WAIT: if (rd_valid) begin
          case (widx)
            2'd0: w_lo <= rd_data;
            2'd1: w_hi <= rd_data;
            2'd2: w_cnt <= rd_data;
            default: begin
              f_trm <= rd_data[31];
              f_lnk <= rd_data[30];
            end
          endcase
          widx <= widx + 2'd1;
          st <= (widx == 2'd3) ? S_DEC : S_REQ;
        end
        S_DEC: begin
          ent_cnt <= ent_cnt + 1'b1;
          if (f_lnk) begin
            if (f_trm) begin
              done_r <= 1'b1;
              st <= S_IDLE;
            end else if (w_lo[3:0] != 4'd0) begin
              err_r <= 1'b1;
              st <= S_IDLE;
            end else begin
              ent_addr <= {w_hi, w_lo};
              st <= S_NEXT;
            end
          end else if (w_cnt != 32'd0) begin
            cur <= {w_hi, w_lo};
            remain <= w_cnt;
            st <= S_EMIT;
          end else if (f_trm) begin
            done_r <= 1'b1;
            st <= S_IDLE;
          end else begin
            ent_addr <= ent_addr + 64'd16;
            st <= S_NEXT;
          end
        end
        S_EMIT: if (seg_ready) begin
          total <= total + TOT_W'(seg_len);
          cur <= cur + 64'(seg_len);
          remain <= remain - seg_len;
          if (last_seg) begin
            if (f_trm) begin
              done_r <= 1'b1;
              st <= S_IDLE;
            end else begin
              ent_addr <= ent_addr + 64'd16;
              st <= S_NEXT;
            end
          end
        end
        S_NEXT: begin
          if (ent_cnt == ENT_LIMIT) begin
            err_r <= 1'b1;
            st <= S_IDLE;
          end else begin
            st <= S_REQ;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  p_rd_align_r1: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |-> rd_addr[1:0] == 2'b00);

  p_seg_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    seg_valid |-> (seg_len != 32'd0 && seg_len <= SEG_MAX));

  p_limit_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |-> ent_cnt < ENT_LIMIT);

  p_done_after_last_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (seg_valid && seg_ready && last_seg && f_trm) |=> done);

  p_done_err_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && error));

  p_seg_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (seg_valid && !seg_ready) |=> (seg_valid && $stable(seg_addr) && $stable(seg_len)));

  p_quiet_end_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (done || error) |-> (!rd_req && !seg_valid));
endmodule

// File: tb/tb_sg_walker.sv
module tb_sg_walker;
  localparam int CLK_P = 10;
  localparam int MSEG  = 64;
  localparam int MENT  = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [63:0] start_addr = '0;
  logic        rd_req, rd_valid;
  logic [63:0] rd_addr;
  logic [31:0] rd_data;
  logic        seg_valid, seg_ready;
  logic [63:0] seg_addr;
  logic [31:0] seg_len;
  logic        done, error;
  logic [39:0] total_bytes;

  sg_walker #(.MAX_SEG(MSEG), .MAX_ENTRIES(MENT), .TOT_W(40)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_valid(rd_valid), .rd_data(rd_data),
    .seg_valid(seg_valid), .seg_addr(seg_addr), .seg_len(seg_len), .seg_ready(seg_ready),
    .done(done), .error(error), .total_bytes(total_bytes));

  always #(CLK_P/2) clk = ~clk;

  logic [31:0] mem [256];
  int   lat = 0;
  int   rmode = 0;
  int   cyc = 0;
  int   nrd = 0;
  int   nseg = 0;
  int   acc_cyc = 0, done_cyc = 0;
  int   stalls = 0, viol = 0;
  logic pend = 1'b0;
  logic [7:0] pidx = '0;
  int   pc = 0;
  logic done_q = 1'b0, stall_q = 1'b0;
  logic [63:0] sa [64];
  logic [31:0] sl [64];
  logic [63:0] hold_a = '0;
  logic [31:0] hold_l = '0;
  int   nchk = 0, nfail = 0;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    rd_valid <= 1'b0;
    if (!rst_n) pend <= 1'b0;
    else if (rd_req) begin
      pend <= 1'b1; pidx <= rd_addr[9:2]; pc <= lat; nrd <= nrd + 1;
    end else if (pend) begin
      if (pc == 0) begin rd_valid <= 1'b1; rd_data <= mem[pidx]; pend <= 1'b0; end
      else pc <= pc - 1;
    end
  end

  always @(posedge clk) begin
    done_q <= done;
    if (rst_n && done && !done_q) done_cyc <= cyc;
    if (rst_n && seg_valid && seg_ready) begin
      sa[nseg % 64] <= seg_addr; sl[nseg % 64] <= seg_len;
      nseg <= nseg + 1; acc_cyc <= cyc;
    end
    if (rst_n && stall_q && !(seg_valid && seg_addr == hold_a && seg_len == hold_l))
      viol <= viol + 1;
    stall_q <= rst_n && seg_valid && !seg_ready;
    if (rst_n && seg_valid && !seg_ready) stalls <= stalls + 1;
    hold_a <= seg_addr; hold_l <= seg_len;
  end

  always @(negedge clk)
    seg_ready <= (rmode == 0) ? 1'b1 : (rmode == 1) ? cyc[0] : (cyc % 3 == 0);

  always @(posedge clk)
    if (cyc > 150000) begin
      $display("FAIL watchdog act=%0d exp=%0d", cyc, 150000);
      $display("End of test - %0d assertions evaluated, %0d failures", nchk + 1, nfail + 1);
      $finish;
    end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic put_ent(input int base, input logic [31:0] lo, input logic [31:0] hi,
                         input logic [31:0] cnt, input logic [31:0] flg);
    mem[(base >> 2) + 0] = lo;
    mem[(base >> 2) + 1] = hi;
    mem[(base >> 2) + 2] = cnt;
    mem[(base >> 2) + 3] = flg;
  endtask

  task automatic walk(input logic [63:0] a);
    @(negedge clk); start = 1'b1; start_addr = a;
    @(negedge clk); start = 1'b0;
    for (int t = 0; t < 3000 && !(done || error); t++) @(negedge clk);
    @(negedge clk);
  endtask

  localparam int VEC [6][4] = '{
    '{1,   0, 1, 1},
    '{64,  1, 1, 64},
    '{65,  2, 2, 1},
    '{128, 0, 2, 64},
    '{200, 1, 4, 8},
    '{0,   0, 0, 0}};

  initial begin
    int s0, r0;
    for (int i = 0; i < 256; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    chk(!rd_req && !seg_valid && !done && !error && total_bytes == 0, "R12 reset idle",
        {rd_req, seg_valid, done, error}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < 6; i++) begin
      rmode = VEC[i][1]; lat = i % 3;
      put_ent(32'h40, 32'h1000_0000 + 32'(i) * 32'h1000, 32'h2, 32'(VEC[i][0]), 32'h8000_0000);
      s0 = nseg;
      walk(64'h40);
      chk(nseg - s0 == VEC[i][2], "R2 segment count", nseg - s0, VEC[i][2]);
      chk(done && !error, "R5 terminal ends walk", {done, error}, 2);
      chk(total_bytes == 40'(VEC[i][0]), "R10 total bytes", total_bytes, VEC[i][0]);
      if (VEC[i][2] > 0) begin
        chk(sl[(nseg - 1) % 64] == 32'(VEC[i][3]), "R2 last length", sl[(nseg - 1) % 64], VEC[i][3]);
        chk(sa[s0 % 64] == {32'h2, 32'h1000_0000 + 32'(i) * 32'h1000}, "R1 first address",
            sa[s0 % 64], {32'h2, 32'h1000_0000 + 32'(i) * 32'h1000});
        chk(done_cyc == acc_cyc + 1, "R9 done timing", done_cyc, acc_cyc + 1);
      end else begin
        chk(nseg == s0, "R6 zero count no segment", nseg - s0, 0);
      end
      if (VEC[i][2] > 1)
        chk(sa[(s0 + 1) % 64] == sa[s0 % 64] + MSEG, "R2 consecutive address",
            sa[(s0 + 1) % 64], sa[s0 % 64] + MSEG);
    end

    rmode = 2; lat = 1;
    put_ent(32'h100, 32'hA000_0000, 32'h0, 32'd10, 32'h3000_0000);
    put_ent(32'h110, 32'h200, 32'h0, 32'hFFFF, 32'h5000_0000);
    put_ent(32'h200, 32'hB000_0000, 32'h1, 32'd20, 32'h8000_0000);
    s0 = nseg; r0 = nrd;
    walk(64'h107);
    chk(nseg - s0 == 2 && sl[s0 % 64] == 10 && sl[(s0 + 1) % 64] == 20, "R3 R4 chain segments",
        nseg - s0, 2);
    chk(sa[(s0 + 1) % 64] == 64'h1_B000_0000, "R4 link target", sa[(s0 + 1) % 64], 64'h1_B000_0000);
    chk(nrd - r0 == 12, "R1 R3 word reads", nrd - r0, 12);
    chk(total_bytes == 30 && done && !error, "R10 chain total", total_bytes, 30);
    chk(stalls > 0 && viol == 0, "R11 stall hold", viol, 0);
    repeat (5) @(negedge clk);
    chk(done && total_bytes == 30, "R10 hold after done", total_bytes, 30);

    s0 = nseg;
    @(negedge clk); start = 1'b1; start_addr = 64'h100;
    @(negedge clk); start = 1'b0;
    for (int t = 0; t < 3000 && !seg_valid; t++) @(negedge clk);
    start = 1'b1; start_addr = 64'h300;
    @(negedge clk); start = 1'b0;
    for (int t = 0; t < 3000 && !(done || error); t++) @(negedge clk);
    chk(nseg - s0 == 2 && total_bytes == 30, "R10 start ignored while busy", total_bytes, 30);

    rmode = 0; lat = 0;
    put_ent(32'h300, 32'h200, 32'h0, 32'd0, 32'hC000_0000);
    s0 = nseg; r0 = nrd;
    walk(64'h300);
    chk(done && nseg == s0 && nrd - r0 == 4, "R5 terminal link not followed", nrd - r0, 4);

    put_ent(32'h300, 32'h208, 32'h0, 32'd0, 32'h4000_0000);
    r0 = nrd;
    walk(64'h300);
    chk(error && !done, "R7 misaligned link error", {done, error}, 1);
    chk(nrd - r0 == 4, "R7 no read after error", nrd - r0, 4);

    for (int k = 0; k < 5; k++)
      put_ent(32'h380 + k * 16, 32'hC000_0000 + 32'(k) * 16, 32'h0, 32'd1, 32'h0);
    s0 = nseg; r0 = nrd;
    walk(64'h380);
    chk(error && !done, "R8 entry limit error", {done, error}, 1);
    chk(nrd - r0 == 16 && nseg - s0 == 4, "R8 fifth entry not read", nrd - r0, 16);

    put_ent(32'h3B0, 32'hC000_0030, 32'h0, 32'd1, 32'h8000_0000);
    walk(64'h380);
    chk(done && !error && total_bytes == 4, "R8 exact limit completes", total_bytes, 4);

    rst_n = 1'b0;
    @(negedge clk);
    chk(!done && !error && total_bytes == 0, "R12 reset clears", total_bytes, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule